// File: doc/BRIEF.md
# Display and Cursor Skew Delay

This block sits at the output of a video timing generator. It takes the raw display-enable and cursor-enable strobes, which the timing logic produces one per character clock, and delays each of them by zero, one or two character clocks before it leaves the controller. The delay can also be set so that the output is held off for good. The two delays are set independently by two 2-bit fields of an 8-bit configuration register. The register is held inside the block and written through a simple write strobe.

A variant select input says whether the controller flavour supports skew at all. On flavours that do not support it, the skew fields are ignored and both strobes pass through with no delay. The low two bits of the same register hold the interlace mode. The block decodes that field into a mode output and does nothing else with it.

The character clock is a clock enable (`char_ce_i`) on the system clock. The delay stages advance only on cycles where it is high.

Top module: `skew_delay_unit`

## Requirements
- R1: The cursor skew code is taken from configuration bits 7..6, and the display skew code from bits 5..4. The two codes act independently.
- R2: Skew code 00 makes the output equal to its raw input in the same clock cycle.
- R3: Skew code 01 outputs the raw value sampled at the most recent character clock. Skew code 10 outputs the value sampled at the character clock before that.
- R4: Skew code 11 holds that output at 0 whatever the raw input does.
- R5: Skew is honoured only when `variant_i` is 0, 3 or 4. For every other variant, both outputs equal their raw inputs in the same cycle, whatever bits 7..4 hold.
- R6: Configuration bits 3..2 have no effect on any output.
- R7: `ilace_mode_o` decodes bits 1..0 as follows: 00 and 10 give 0 (none), 01 gives 1 (sync only), and 11 gives 2 (sync and video).
- R8: The configuration register resets to 0. A write with `cfg_we_i` high is applied at the clock edge and governs the outputs from the next cycle on.
- R9: The delay stages shift only on cycles where `char_ce_i` is high. Changing a skew code does not clear the stages, so history captured under the old code appears at once under the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| char_ce_i | input | 1 | Character clock enable |
| variant_i | input | 3 | Controller flavour select |
| cfg_we_i | input | 1 | Configuration register write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| disp_raw_i | input | 1 | Raw display-enable strobe |
| cur_raw_i | input | 1 | Raw cursor-enable strobe |
| disp_en_o | output | 1 | Skewed display enable |
| cur_en_o | output | 1 | Skewed cursor enable |
| ilace_mode_o | output | 2 | Decoded interlace mode |

## Verification
A wrong value in a delay stage stays hidden while the code is 00 or 11. It shows on the output in the first cycle a code of 01 or 10 selects that stage, and it lasts until one or two further character clocks push it out. A stage that shifts on a cycle without a character clock, or one that is cleared when the code changes, moves the output edges by whole character clocks. The bench therefore thins out `char_ce_i` and switches codes in the middle of a stream. A register bit wired to the wrong field shows in the same cycle on the other signal or on the mode output, so all field combinations are swept on every variant.

// File: rtl/skew_pkg.sv
package skew_pkg;
  typedef enum logic [1:0] {
    ILACE_NONE       = 2'd0,
    ILACE_SYNC       = 2'd1,
    ILACE_SYNC_VIDEO = 2'd2
  } ilace_e;

  typedef struct packed {
    logic [1:0] cur_skew;
    logic [1:0] disp_skew;
    logic [1:0] spare;
    logic [1:0] ilace;
  } skew_cfg_t;

  localparam logic [1:0] SKEW_NONE = 2'b00;
  localparam logic [1:0] SKEW_OFF  = 2'b11;

  function automatic ilace_e decode_ilace(input logic [1:0] f);
    unique case (f)
      2'b01:   return ILACE_SYNC;
      2'b11:   return ILACE_SYNC_VIDEO;
      default: return ILACE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/skew_cfg_reg.sv
module skew_cfg_reg
  import skew_pkg::*;
#(
  parameter int unsigned VAR_W = 3,
  parameter logic [(1<<VAR_W)-1:0] SKEW_VAR_MASK = 'b0001_1001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [7:0]       wdata_i,
  input  logic [VAR_W-1:0] variant_i,
  output logic [1:0]       disp_code_o,
  output logic [1:0]       cur_code_o,
  output ilace_e           ilace_o
);
  skew_cfg_t cfg_q;
  logic      honoured;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= skew_cfg_t'(wdata_i);
  end

  assign honoured    = SKEW_VAR_MASK[variant_i];
  assign disp_code_o = honoured ? cfg_q.disp_skew : SKEW_NONE;
  assign cur_code_o  = honoured ? cfg_q.cur_skew  : SKEW_NONE;
  assign ilace_o     = decode_ilace(cfg_q.ilace);

  p_write_lands_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ilace_o == decode_ilace($past(wdata_i[1:0]))));
  p_ilace_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilace_o != ilace_e'(2'b11));
endmodule

// File: rtl/skew_line.sv
module skew_line #(
  parameter int unsigned DEPTH  = 2,
  parameter int unsigned CODE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              raw_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              out_o
);
  localparam int unsigned N_TAP = DEPTH + 1;

  logic [DEPTH:1]   stage_q;
  logic [N_TAP-1:0] taps;

  assign taps[0] = raw_i;

  for (genvar k = 1; k <= DEPTH; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   stage_q[k] <= 1'b0;
      else if (ce_i) stage_q[k] <= taps[k-1];
    end
    assign taps[k] = stage_q[k];
  end

  // codes beyond the last tap force the output off
  always_comb begin
    out_o = 1'b0;
    if (int'(code_i) < N_TAP) out_o = taps[code_i];
  end

  p_hold_no_ce_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(stage_q));
endmodule

// File: rtl/skew_delay_unit.sv
module skew_delay_unit
  import skew_pkg::*;
#(
  parameter int unsigned VAR_W = 3,
  parameter int unsigned DEPTH = 2,
  parameter logic [(1<<VAR_W)-1:0] SKEW_VAR_MASK = 'b0001_1001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             char_ce_i,
  input  logic [VAR_W-1:0] variant_i,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_wdata_i,
  input  logic             disp_raw_i,
  input  logic             cur_raw_i,
  output logic             disp_en_o,
  output logic             cur_en_o,
  output logic [1:0]       ilace_mode_o
);
  logic [1:0] disp_code, cur_code;
  ilace_e     ilace;

  skew_cfg_reg #(.VAR_W(VAR_W), .SKEW_VAR_MASK(SKEW_VAR_MASK)) i_cfg (
    .clk_i, .rst_ni,
    .we_i        (cfg_we_i),
    .wdata_i     (cfg_wdata_i),
    .variant_i,
    .disp_code_o (disp_code),
    .cur_code_o  (cur_code),
    .ilace_o     (ilace)
  );

  skew_line #(.DEPTH(DEPTH), .CODE_W(2)) i_disp (
    .clk_i, .rst_ni, .ce_i(char_ce_i),
    .raw_i(disp_raw_i), .code_i(disp_code), .out_o(disp_en_o)
  );

  skew_line #(.DEPTH(DEPTH), .CODE_W(2)) i_cur (
    .clk_i, .rst_ni, .ce_i(char_ce_i),
    .raw_i(cur_raw_i), .code_i(cur_code), .out_o(cur_en_o)
  );

  assign ilace_mode_o = ilace;

  p_nodelay_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_code == SKEW_NONE) |-> (disp_en_o == disp_raw_i));
  p_off_disp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_code == SKEW_OFF) |-> !disp_en_o);
  p_off_cur_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_code == SKEW_OFF) |-> !cur_en_o);
  p_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !SKEW_VAR_MASK[variant_i] |-> (disp_en_o == disp_raw_i && cur_en_o == cur_raw_i));
endmodule

// File: tb/test_skew_delay_unit.sv
module test_skew_delay_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0;
  logic [2:0] variant = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic       d_raw = 1'b0, c_raw = 1'b0;
  logic       d_en, c_en;
  logic [1:0] mode;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R8";

  // behavioural model state
  int m_cfg = 0;
  bit dh[$], ch[$];

  always #4 clk = ~clk;

  skew_delay_unit i_skew_delay_unit (
    .clk_i(clk), .rst_ni(rst_n), .char_ce_i(ce), .variant_i(variant),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .disp_raw_i(d_raw), .cur_raw_i(c_raw),
    .disp_en_o(d_en), .cur_en_o(c_en), .ilace_mode_o(mode)
  );

  function automatic bit honoured(int v);
    return (v == 0 || v == 3 || v == 4);
  endfunction

  function automatic bit expect_out(int code, bit raw, bit h[$]);
    case (code)
      0: return raw;
      1: return h[0];
      2: return h[1];
      default: return 1'b0;
    endcase
  endfunction

  function automatic int expect_mode(int f);
    if (f == 1) return 1;
    if (f == 3) return 2;
    return 0;
  endfunction

  task automatic check_now();
    int dc, cc;
    bit ed, ec;
    int em;
    dc = honoured(variant) ? (m_cfg >> 4) & 3 : 0;
    cc = honoured(variant) ? (m_cfg >> 6) & 3 : 0;
    ed = expect_out(dc, d_raw, dh);
    ec = expect_out(cc, c_raw, ch);
    em = expect_mode(m_cfg & 3);
    checks++;
    if (d_en !== ed) begin
      errors++;
      $display("FAIL %s disp_en: got %0b exp %0b (cfg %02h var %0d)", tag, d_en, ed, m_cfg, variant);
    end
    checks++;
    if (c_en !== ec) begin
      errors++;
      $display("FAIL %s cur_en (R1 field): got %0b exp %0b (cfg %02h var %0d)", tag, c_en, ec, m_cfg, variant);
    end
    checks++;
    if (int'(mode) !== em) begin
      errors++;
      $display("FAIL %s ilace_mode: got %0d exp %0d (cfg %02h)", tag, mode, em, m_cfg);
    end
  endtask

  // drive at negedge, check before posedge, advance model at posedge
  task automatic step(bit ce_v, bit d_v, bit c_v, bit we_v, int wd);
    @(negedge clk);
    ce = ce_v; d_raw = d_v; c_raw = c_v; we = we_v; wdata = wd[7:0];
    #2;
    check_now();
    @(posedge clk);
    if (ce_v) begin
      dh.push_front(d_v); void'(dh.pop_back());
      ch.push_front(c_v); void'(ch.pop_back());
    end
    if (we_v) m_cfg = wd & 8'hff;
  endtask

  task automatic stream(int n, int ce_pct);
    for (int i = 0; i < n; i++)
      step(($urandom % 100) < ce_pct, $urandom % 2, $urandom % 2, 1'b0, 0);
  endtask

  initial begin
    dh = '{0, 0}; ch = '{0, 0};
    #20;
    // R8: reset state, register zero: pass-through and mode none
    tag = "R8";
    @(negedge clk); d_raw = 1; c_raw = 1; #2; check_now();
    @(negedge clk); rst_n = 1'b1;
    stream(6, 100);

    // R1 R2 R3 R4: every pair of skew codes on honoured variants
    for (int v = 0; v < 5; v++) begin
      if (!honoured(v)) continue;
      variant = 3'(v);
      for (int c = 0; c < 16; c++) begin
        tag = (c == 0) ? "R2" : ((c & 3) == 3 || (c >> 2) == 3) ? "R4" : "R3";
        step(1'b1, 1'b0, 1'b0, 1'b1, (c << 4) | (c & 3));
        stream(10, 100);
      end
    end

    // R6: spare bits toggled, nothing may change
    tag = "R6";
    variant = 3'd0;
    for (int c = 0; c < 16; c++) begin
      step(1'b1, 1'b1, 1'b0, 1'b1, 8'h60 | (c << 2 & 8'h0c) | (c & 3));
      stream(5, 100);
    end

    // R5: non-honoured variants ignore skew fields
    tag = "R5";
    for (int v = 0; v < 8; v++) begin
      if (honoured(v)) continue;
      variant = 3'(v);
      step(1'b1, 1'b0, 1'b1, 1'b1, 8'hf1);
      stream(8, 100);
      step(1'b1, 1'b1, 1'b0, 1'b1, 8'h6b);
      stream(8, 100);
    end

    // R9: sparse character clocks
    tag = "R9";
    variant = 3'd3;
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h90);
    stream(60, 30);
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h60);
    stream(60, 30);

    // R9: code changes mid-stream keep history
    for (int i = 0; i < 40; i++) begin
      step($urandom % 2, $urandom % 2, $urandom % 2, 1'b1, ($urandom % 256));
      step(1'b0, $urandom % 2, $urandom % 2, 1'b0, 0);
    end

    // R7: interlace decode with all field values
    tag = "R7";
    variant = 3'd1;
    for (int f = 0; f < 4; f++) begin
      step(1'b1, 1'b0, 1'b0, 1'b1, f);
      step(1'b1, 1'b0, 1'b0, 1'b0, 0);
    end

    // R8: write then reset returns register to zero
    tag = "R8";
    variant = 3'd4;
    step(1'b1, 1'b1, 1'b1, 1'b1, 8'hff);
    step(1'b1, 1'b1, 1'b1, 1'b0, 0);
    @(negedge clk); rst_n = 1'b0;
    m_cfg = 0; dh = '{0, 0}; ch = '{0, 0};
    @(negedge clk); rst_n = 1'b1;
    stream(6, 100);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not end, got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule